// File: doc/BRIEF.md
# Pending-Interrupt Priority Scanner

This block searches a pending bitmap held in memory for the best pending message-based interrupt. After a start pulse it reads the bitmap one byte at a time. For every set bit in a fetched byte it reads that interrupt's configuration byte, and it keeps the enabled entry with the numerically smallest priority. The interrupt ID space starts at 8192. The bitmap still holds a bit for every ID below that value, so the walk begins at byte offset 1024. It stops before byte offset 2^(idbits+1)/8, where idbits is the programmed ID-width field limited to the largest value the implementation supports.

Memory is reached through one byte-read port. The block raises a one-cycle request with an address and then waits for a valid strobe that carries the data byte. It never has more than one read outstanding. When the scan ends, the block raises a one-cycle done pulse. The winning ID, its priority and a found flag then stay fixed until the next start.

Top module: `lpi_prio_scan`

## Requirements
- R1: A start while `lpi_en` is 0, `pend_base` is 0 or `cfg_base` is 0 issues no read. `done` pulses on the next cycle with `found`=0 and `best_prio`=8'hFF.
- R2: The effective ID width is min(`id_bits`, MAX_IDBITS). Pending reads go to `pend_base`+offset for every offset from 1024 up to 2^(eff+1)/8 − 1, in ascending order, one read per offset. Bytes below offset 1024 are never read.
- R3: When 2^(eff+1) ≤ 8192 (for example `id_bits` ≤ 12), the scan issues no read and ends with `done`, `found`=0 and `best_prio`=8'hFF.
- R4: Every set bit of a fetched pending byte is evaluated, lowest bit first. Bit b of the byte at offset o stands for ID o*8+b, and its configuration byte is read at `cfg_base`+(ID−8192). There is exactly one configuration read per set bit.
- R5: In a configuration byte, bit 0 is the enable and bits [7:2] are the priority. An entry whose bit 0 is 0 is never selected.
- R6: A numerically lower priority replaces the current best. On equal priority the lower ID is kept.
- R7: `best_prio` reports the configuration byte with bits [1:0] forced to 0. At each start it returns to 8'hFF with `found`=0, and it stays there when no enabled entry is pending.
- R8: `done` is high for exactly one cycle at the end of a scan. `best_id`, `best_prio` and `found` hold their values until the next start.
- R9: At most one read is outstanding. `rd_valid` is accepted only while the block waits for a read, and a strobe at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| lpi_en | input | 1 | Message-interrupt enable |
| pend_base | input | ADDR_W | Byte address of the pending bitmap |
| cfg_base | input | ADDR_W | Byte address of the configuration byte of ID 8192 |
| id_bits | input | IDB_W | Programmed ID-width field |
| rd_req | output | 1 | One-cycle byte-read request |
| rd_addr | output | ADDR_W | Read address, valid with `rd_req` |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 8 | Read data byte |
| best_id | output | MAX_IDBITS+1 | Winning interrupt ID |
| best_prio | output | 8 | Winning priority, 8'hFF if none |
| found | output | 1 | An enabled pending entry was selected |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The hardest situations to reach are a pending byte with several set bits whose priorities compete, and ties between IDs that are far apart. Each happens only when the memory holds a matching combination of pending and configuration bytes. The bench preloads its memory model with such combinations: a full byte with priorities that fall toward the top bit, equal priorities spread over several bytes, pending bits planted below the first interrupt ID, and sparse random patterns. It answers reads with a varying latency and sends stray valid strobes whenever no read is outstanding. It checks the count and order of the reads as well as the final result.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_PWAIT,
        S_BITS,
        S_CWAIT,
        S_FIN
    } scan_state_e;

    // Priority key of a configuration byte: bits [7:2], low bits zero.
    function automatic logic [7:0] prio_key(input logic [7:0] cfg);
        return cfg & 8'hFC;
    endfunction

    // Index of the lowest set bit (0 when the byte is empty).
    function automatic logic [2:0] low_bit(input logic [7:0] b);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (b[i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/lpi_scan_range.sv
module lpi_scan_range #(
    parameter int MAX_IDBITS = 13,
    parameter int IDB_W      = 5,
    parameter int OFF_W      = 12
) (
    input  logic [IDB_W-1:0] id_bits,
    output logic [OFF_W-1:0] end_off
);
    logic [IDB_W-1:0] eff;

    always_comb begin
        eff = (id_bits > IDB_W'(MAX_IDBITS)) ? IDB_W'(MAX_IDBITS) : id_bits;
        // 2^(eff+1) bits = 2^(eff-2) bytes
        if (eff < IDB_W'(2)) end_off = '0;
        else                 end_off = OFF_W'(1) << (eff - IDB_W'(2));
    end

    always_comb begin
        AST_END_WITHIN_TABLE: assert (end_off <= (OFF_W'(1) << (OFF_W - 1))); // R2
    end
endmodule

// File: rtl/lpi_best_tracker.sv
module lpi_best_tracker
    import lpi_scan_pkg::*;
#(
    parameter int ID_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            offer,
    input  logic [ID_W-1:0] offer_id,
    input  logic [7:0]      offer_cfg,
    output logic [ID_W-1:0] best_id,
    output logic [7:0]      best_prio,
    output logic            found
);
    typedef struct packed {
        logic [ID_W-1:0] id;
        logic [7:0]      prio;
        logic            hit;
    } best_t;

    best_t cur;
    logic  wins;

    assign wins = offer && offer_cfg[0] && (prio_key(offer_cfg) < cur.prio);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur <= '{id: '0, prio: 8'hFF, hit: 1'b0};
        end else if (wins) begin
            cur <= '{id: offer_id, prio: prio_key(offer_cfg), hit: 1'b1};
        end
    end

    assign best_id   = cur.id;
    assign best_prio = cur.prio;
    assign found     = cur.hit;

    AST_PRIO_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (best_prio <= $past(best_prio))); // R6
    AST_DISABLED_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        (offer && !offer_cfg[0] && !clear) |=> ($stable(best_id) && $stable(best_prio))); // R5
    AST_PRIO_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        found |-> (best_prio[1:0] == 2'b00)); // R7
    AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!clear && !offer) |=> ($stable(best_id) && $stable(found))); // R8
endmodule

// File: rtl/lpi_scan_ctrl.sv
module lpi_scan_ctrl
    import lpi_scan_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 14,
    parameter int OFF_W     = 12,
    parameter int FIRST_LPI = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              lpi_en,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [OFF_W-1:0]  end_off,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              clear,
    output logic              offer,
    output logic [ID_W-1:0]   offer_id,
    output logic [7:0]        offer_cfg,
    output logic              done
);
    localparam int FIRST_BYTE = FIRST_LPI / 8;

    scan_state_e     state, state_nx;
    logic [OFF_W-1:0] off;
    logic [7:0]       work;
    logic [ID_W-1:0]  cur_id;
    logic [2:0]       bit_sel;
    logic [ID_W-1:0]  bit_id;
    logic             ready;

    assign ready   = lpi_en && (pend_base != '0) && (cfg_base != '0);
    assign bit_sel = low_bit(work);
    assign bit_id  = {off[OFF_W-2:0], bit_sel};

    always_comb begin
        state_nx = state;
        rd_req   = 1'b0;
        rd_addr  = '0;
        unique case (state)
            S_IDLE:  if (start) state_nx = ready ? S_CHECK : S_FIN;
            S_CHECK: begin
                if (off >= end_off) begin
                    state_nx = S_FIN;
                end else begin
                    rd_req   = 1'b1;
                    rd_addr  = pend_base + ADDR_W'(off);
                    state_nx = S_PWAIT;
                end
            end
            S_PWAIT: if (rd_valid) state_nx = S_BITS;
            S_BITS: begin
                if (work == 8'h00) begin
                    state_nx = S_CHECK;
                end else begin
                    rd_req   = 1'b1;
                    rd_addr  = cfg_base + ADDR_W'(bit_id) - ADDR_W'(FIRST_LPI);
                    state_nx = S_CWAIT;
                end
            end
            S_CWAIT: if (rd_valid) state_nx = S_BITS;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            off    <= '0;
            work   <= '0;
            cur_id <= '0;
        end else begin
            state <= state_nx;
            case (state)
                S_IDLE:  off <= OFF_W'(FIRST_BYTE);
                S_PWAIT: if (rd_valid) work <= rd_data;
                S_BITS: begin
                    if (work == 8'h00) begin
                        off <= off + OFF_W'(1);
                    end else begin
                        cur_id        <= bit_id;
                        work[bit_sel] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign clear     = (state == S_IDLE) && start;
    assign offer     = (state == S_CWAIT) && rd_valid;
    assign offer_id  = cur_id;
    assign offer_cfg = rd_data;
    assign done      = (state == S_FIN);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && !ready) |=> (done && !rd_req)); // R1
    AST_PEND_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && rd_req) |-> (off >= OFF_W'(FIRST_BYTE) && off < end_off)); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (state == S_PWAIT || state == S_CWAIT) |-> !rd_req); // R9
    AST_CFG_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
        offer |-> (offer_id >= ID_W'(FIRST_LPI))); // R4
endmodule

// File: rtl/lpi_prio_scan.sv
module lpi_prio_scan #(
    parameter int ADDR_W     = 32,
    parameter int MAX_IDBITS = 13,
    parameter int IDB_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  lpi_en,
    input  logic [ADDR_W-1:0]     pend_base,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [IDB_W-1:0]      id_bits,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_valid,
    input  logic [7:0]            rd_data,
    output logic [MAX_IDBITS:0]   best_id,
    output logic [7:0]            best_prio,
    output logic                  found,
    output logic                  done
);
    localparam int ID_W      = MAX_IDBITS + 1;
    localparam int OFF_W     = ID_W - 2;
    localparam int FIRST_LPI = 8192;

    logic [OFF_W-1:0] end_off;
    logic             clear, offer;
    logic [ID_W-1:0]  offer_id;
    logic [7:0]       offer_cfg;

    lpi_scan_range #(.MAX_IDBITS(MAX_IDBITS), .IDB_W(IDB_W), .OFF_W(OFF_W)) u_range (
        .id_bits (id_bits),
        .end_off (end_off)
    );

    lpi_scan_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .OFF_W(OFF_W), .FIRST_LPI(FIRST_LPI)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .lpi_en    (lpi_en),
        .pend_base (pend_base),
        .cfg_base  (cfg_base),
        .end_off   (end_off),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .clear     (clear),
        .offer     (offer),
        .offer_id  (offer_id),
        .offer_cfg (offer_cfg),
        .done      (done)
    );

    lpi_best_tracker #(.ID_W(ID_W)) u_best (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .offer     (offer),
        .offer_id  (offer_id),
        .offer_cfg (offer_cfg),
        .best_id   (best_id),
        .best_prio (best_prio),
        .found     (found)
    );
endmodule

// File: tb/tb_lpi_prio_scan.sv
module tb_lpi_prio_scan;
    localparam int ADDR_W = 32;
    localparam int MAXB   = 13;
    localparam int PBYTES = 2048;
    localparam int NCFG   = 8192;
    localparam logic [31:0] PB = 32'h4000_0000;
    localparam logic [31:0] CB = 32'h8000_0000;

    logic clk = 0, rst = 1, start = 0, lpi_en = 0;
    logic [31:0] pend_base = 0, cfg_base = 0;
    logic [4:0]  id_bits = 0;
    logic rd_req, rd_valid = 0;
    logic [31:0] rd_addr;
    logic [7:0]  rd_data = 0;
    logic [MAXB:0] best_id;
    logic [7:0]  best_prio;
    logic found, done;

    lpi_prio_scan #(.ADDR_W(ADDR_W), .MAX_IDBITS(MAXB), .IDB_W(5)) dut (.*);

    always #4 clk = ~clk;

    logic [7:0] pend_mem [0:PBYTES-1];
    logic [7:0] cfg_mem  [0:NCFG-1];

    int checks = 0, fails = 0;
    int pend_cnt, cfg_cnt, order_err, proto_err, next_poff, last_cfg;
    logic busy_r = 0;
    int lat = 0;
    logic [31:0] hold_addr;
    logic [15:0] lfsr = 16'hACE1;
    logic spur_en = 1;
    int cyc_total = 0;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lookup(input logic [31:0] a);
        if (a >= PB && a < PB + PBYTES) return pend_mem[a - PB];
        if (a >= CB && a < CB + NCFG)   return cfg_mem[a - CB];
        return 8'h00;
    endfunction

    // memory model, acting on the falling edge
    always @(negedge clk) begin
        cyc_total++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (busy_r) begin
            if (rd_req) proto_err++;
            if (lat == 0) begin
                rd_valid = 1;
                rd_data  = lookup(hold_addr);
                busy_r   = 0;
            end else begin
                rd_valid = 0;
                lat--;
            end
        end else begin
            rd_valid = spur_en & lfsr[3] & lfsr[7];
            rd_data  = lfsr[15:8];
            if (rd_req) begin
                hold_addr = rd_addr;
                busy_r    = 1;
                lat       = int'(lfsr[1:0]) % 3;
                if (rd_addr >= PB && rd_addr < PB + PBYTES) begin
                    pend_cnt++;
                    if (int'(rd_addr - PB) != next_poff) order_err++;
                    next_poff++;
                end else if (rd_addr >= CB && rd_addr < CB + NCFG) begin
                    cfg_cnt++;
                    if (int'(rd_addr - CB) <= last_cfg) order_err++;
                    if (!pend_mem[(int'(rd_addr - CB) + 8192) / 8][(int'(rd_addr - CB) + 8192) % 8])
                        order_err++;
                    last_cfg = int'(rd_addr - CB);
                end else begin
                    order_err++;
                end
            end
        end
    end

    // global watchdog
    always @(negedge clk) begin
        if (cyc_total > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < PBYTES; i++) pend_mem[i] = 8'h00;
        for (int i = 0; i < NCFG; i++)   cfg_mem[i]  = 8'h00;
    endtask

    task automatic run_scan(input logic en, input logic [31:0] pb, input logic [31:0] cb,
                            input logic [4:0] idb, input string tag);
        int eff, endb, exp_p, exp_c, exp_id, cyc;
        logic [7:0] exp_pr, c;
        logic exp_f;
        logic [MAXB:0] id_s;
        logic [7:0] pr_s;
        logic f_s;
        eff    = (int'(idb) > MAXB) ? MAXB : int'(idb);
        endb   = (1 << (eff + 1)) / 8;
        exp_pr = 8'hFF; exp_id = 0; exp_f = 0; exp_p = 0; exp_c = 0;
        if (en && pb != 0 && cb != 0) begin
            for (int o = 1024; o < endb; o++) begin
                exp_p++;
                for (int b = 0; b < 8; b++) begin
                    if (pend_mem[o][b]) begin
                        exp_c++;
                        c = cfg_mem[o * 8 + b - 8192];
                        if (c[0] && (c & 8'hFC) < exp_pr) begin
                            exp_pr = c & 8'hFC; exp_id = o * 8 + b; exp_f = 1;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        lpi_en = en; pend_base = pb; cfg_base = cb; id_bits = idb;
        pend_cnt = 0; cfg_cnt = 0; order_err = 0; proto_err = 0;
        next_poff = 1024; last_cfg = -1;
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 0;
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        check(done === 1'b1, {tag, " R8 done seen"}, done, 1);
        if (!(en && pb != 0 && cb != 0))
            check(cyc == 0, {tag, " R1 done next cycle"}, cyc, 0);
        check(pend_cnt == exp_p, {tag, " R2/R3 pending reads"}, pend_cnt, exp_p);
        check(cfg_cnt == exp_c, {tag, " R4 config reads"}, cfg_cnt, exp_c);
        check(order_err == 0, {tag, " R2 R4 read order"}, order_err, 0);
        check(proto_err == 0, {tag, " R9 one outstanding"}, proto_err, 0);
        check(found === exp_f, {tag, " R5 R7 found"}, found, exp_f);
        check(best_prio === exp_pr, {tag, " R6 R7 prio"}, best_prio, exp_pr);
        if (exp_f) check(int'(best_id) == exp_id, {tag, " R6 id"}, best_id, exp_id);
        id_s = best_id; pr_s = best_prio; f_s = found;
        @(negedge clk);
        check(done === 1'b0, {tag, " R8 done one cycle"}, done, 0);
        for (int k = 0; k < 6; k++) @(negedge clk);
        check(best_id === id_s && best_prio === pr_s && found === f_s,
              {tag, " R8 result held"}, {best_id, best_prio}, {id_s, pr_s});
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(done === 1'b0 && rd_req === 1'b0, "reset R8", {done, rd_req}, 0);
        check(found === 1'b0 && best_prio === 8'hFF, "reset R7", best_prio, 8'hFF);

        // sparse random pattern, also bits in the reserved low region
        for (int o = 0; o < PBYTES; o++) begin
            pend_mem[o] = ((o * 37) % 11 == 0) ? 8'(o * 73 + 5) & 8'h93 : 8'h00;
        end
        pend_mem[20] = 8'hFF; pend_mem[1023] = 8'hFF;
        for (int i = 0; i < NCFG; i++) cfg_mem[i] = 8'((i * 151 + 29) % 256) | 8'h40;

        run_scan(0, PB, CB, 13, "lpi off");     // R1
        run_scan(1, 0,  CB, 13, "pend base 0"); // R1
        run_scan(1, PB, 0,  13, "cfg base 0");  // R1
        run_scan(1, PB, CB, 12, "idbits 12");   // R3
        run_scan(1, PB, CB, 2,  "idbits 2");    // R3
        run_scan(1, PB, CB, 0,  "idbits 0");    // R3
        run_scan(1, PB, CB, 13, "sparse");      // R2 R4 R5 R6
        run_scan(1, PB, CB, 20, "clamped");     // R2

        // ties: equal priority at distant IDs, low region holds a bait bit
        clear_mem();
        for (int i = 0; i < NCFG; i++) cfg_mem[i] = 8'h81;
        pend_mem[1100][3] = 1; pend_mem[1100][4] = 1; pend_mem[1900][0] = 1;
        cfg_mem[1100 * 8 + 3 - 8192] = 8'h43;
        cfg_mem[1100 * 8 + 4 - 8192] = 8'h41;
        cfg_mem[1900 * 8 - 8192]     = 8'h41;
        pend_mem[5] = 8'h01;
        run_scan(1, PB, CB, 13, "tie");         // R6

        // one full byte, priority falls toward the top bit
        clear_mem();
        pend_mem[1500] = 8'hFF;
        for (int b = 0; b < 8; b++) cfg_mem[1500 * 8 + b - 8192] = 8'(((7 - b) * 8) << 2) | 8'h01;
        run_scan(1, PB, CB, 13, "full byte");   // R4

        // better priorities present but disabled
        cfg_mem[1500 * 8 + 7 - 8192] = 8'h00;
        cfg_mem[1500 * 8 + 6 - 8192] = 8'h04;
        run_scan(1, PB, CB, 13, "disabled top"); // R5
        for (int b = 0; b < 8; b++) cfg_mem[1500 * 8 + b - 8192] = 8'hFE;
        run_scan(1, PB, CB, 14, "all disabled"); // R5 R7

        // no stray strobes, lowest priority value 0 at last ID
        spur_en = 0;
        clear_mem();
        pend_mem[2047] = 8'h80; pend_mem[1024] = 8'h01;
        cfg_mem[NCFG - 1] = 8'h03; cfg_mem[0] = 8'h07;
        run_scan(1, PB, CB, 13, "edges");       // R2 R7

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule